// File: doc/BRIEF.md
# Serial Port Receive-Queue Register Block

This block is the software-visible register file of a serial controller. A byte-wide bus reaches a mode register, a control register, a transmit data port, a status register, a receive data port, a queue control register and a queue level register. Received characters arrive one byte per cycle on a stream input and are stored in a 16-deep receive queue. Software reads them back one at a time. The serializer and baud logic sit outside the block. Outward, the block only presents a byte strobe for each transmit write and the receive and transmit interrupt lines.

Status flags are sticky. A flag clears only when software writes a zero to its bit, and writing a one leaves it as it is. The receive side raises its "threshold reached" flag and, when enabled, the receive interrupt as soon as the queue holds at least the programmed trigger level. If fewer bytes than the trigger level are waiting, a character timer runs. The timer measures 15 time units from the last accepted byte, where one time unit is a programmable number of clock cycles. When the timer expires, the block reports the waiting data in the same way. Reading the status register while the transmitter is enabled marks the transmitter idle again, so a polling driver always sees it free.

Read data is combinational from the address. Any side effect of a read, such as a queue pop or the transmit re-arm, takes place at the clock edge that ends the read cycle.

Top module: `serial_fifo_port`

## Requirements
- R1: The receive queue returns bytes in arrival order. A read at offset 0x14 returns the oldest byte and removes it. On an empty queue that read returns 0x00 and changes nothing. The level register at 0x1C reads back the number of stored bytes.
- R2: The status register at 0x10 reads transmit-end on bit 6, transmit-empty on bit 5, break on bit 4, threshold-reached on bit 1 and data-ready on bit 0. Bits 7, 3 and 2 always read 0.
- R3: A status write clears every one of the five flags whose written bit is 0. A flag whose written bit is 1 keeps its value.
- R4: A status write with bit 1 or bit 0 at 0 drops the receive interrupt in the next cycle.
- R5: When an accepted byte brings the level to the trigger level or above, threshold-reached is set in the next cycle and the character timer is stopped. If control bit 6 (receive interrupt enable) is 1, the receive interrupt rises in that same cycle.
- R6: An accepted byte that leaves the level below the trigger restarts the character timer. Fifteen time units after that byte, threshold-reached and data-ready are set, and the receive interrupt rises if control bit 6 is 1. A time unit is `unit_cycles` clocks, and a value of 0 counts as 1.
- R7: A pop that leaves the level below the trigger clears threshold-reached.
- R8: Mode writes store the value AND 0x7B. Control writes store the value AND 0xFA. A control write with bit 5 at 0 sets transmit-end. Bit 7 of every control write appears on `tx_irq` one cycle later.
- R9: A status read while control bit 5 (transmit enable) is 1 returns the current flags, and then sets transmit-empty and transmit-end.
- R10: Stream bytes are stored only while control bit 4 (receive enable) is 1. A `brk_evt` pulse sets the break flag.
- R11: After reset, status reads 0x60, control reads 0x20, mode and queue control read 0x00, the queue is empty with zeroed storage, and every output is low.
- R12: A byte that arrives while the queue holds 16 entries is dropped, and the level stays at 16.
- R13: Bits 7:6 of the queue control register at 0x18 select the trigger level: 00 selects 1, 01 selects 4, 10 selects 8 and 11 selects 14.
- R14: A write to 0x0C pulses `tx_push` for one cycle in the cycle after the write, with the written byte on `tx_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe, acts at the clock edge |
| bus_rd | input | 1 | Read strobe; side effects act at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| rx_valid | input | 1 | Received byte valid |
| rx_byte | input | 8 | Received byte |
| brk_evt | input | 1 | Line break detected |
| unit_cycles | input | 16 | Clock cycles per time unit |
| tx_push | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| rx_irq | output | 1 | Receive interrupt |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
Register contents, flags, `rx_irq`, `tx_irq` and `tx_push` all change at the edge that ends the access or the stream beat, so they are due one cycle after the stimulus. The bench samples pins at the falling edge after that clock edge. Read data is combinational, so the scoreboard compares it at the falling edge inside the read cycle. That value reflects the state from before the read's own side effect. The character timeout lands exactly 15 × `unit_cycles` edges after the last accepted byte. The bench brackets that instant with one read well before it and one well after it, and never samples near the edge itself.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;

   // Register byte offsets (software decodes these)
   localparam logic [4:0] OFS_MODE = 5'h00;
   localparam logic [4:0] OFS_CTRL = 5'h08;
   localparam logic [4:0] OFS_TXD  = 5'h0C;
   localparam logic [4:0] OFS_STAT = 5'h10;
   localparam logic [4:0] OFS_RXD  = 5'h14;
   localparam logic [4:0] OFS_FCTL = 5'h18;
   localparam logic [4:0] OFS_LVL  = 5'h1C;

   // Control register bits
   localparam int CT_TXIE = 7;
   localparam int CT_RXIE = 6;
   localparam int CT_TXEN = 5;
   localparam int CT_RXEN = 4;

   // Status register bits
   localparam int ST_TEND = 6;
   localparam int ST_TDE  = 5;
   localparam int ST_BRK  = 4;
   localparam int ST_RDF  = 1;
   localparam int ST_DR   = 0;

   localparam logic [7:0] MODE_MASK = 8'h7B;
   localparam logic [7:0] CTRL_MASK = 8'hFA;
   localparam logic [7:0] CTRL_RST  = 8'h20;

   typedef struct packed {
      logic tend;
      logic tde;
      logic brk;
      logic rdf;
      logic dr;
   } stat_flags_t;

   function automatic logic [4:0] trig_level(input logic [1:0] sel);
      case (sel)
         2'd0:    return 5'd1;
         2'd1:    return 5'd4;
         2'd2:    return 5'd8;
         default: return 5'd14;
      endcase
   endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int DEPTH = 16,
   parameter int DW    = 8,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_i,
   input  logic          pop_i,
   input  logic [DW-1:0] din_i,
   output logic [DW-1:0] dout_o,
   output logic [CW-1:0] count_o,
   output logic          full_o,
   output logic          empty_o
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rxq_store: DEPTH must be a power of two of at least 2");
   end

   logic [DW-1:0] slot_q [DEPTH];
   logic [PW-1:0] wp_q, rp_q;
   logic [CW-1:0] cnt_q;
   logic          wr_en, rd_en;

   assign full_o  = (cnt_q == CW'(DEPTH));
   assign empty_o = (cnt_q == '0);
   assign wr_en   = push_i && !full_o;
   assign rd_en   = pop_i && !empty_o;
   assign dout_o  = slot_q[rp_q];
   assign count_o = cnt_q;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                       slot_q[i] <= '0;
         else if (wr_en && wp_q == PW'(i)) slot_q[i] <= din_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (wr_en) wp_q <= wp_q + PW'(1);
         if (rd_en) rp_q <= rp_q + PW'(1);
         case ({wr_en, rd_en})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assert_count_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH));

   assert_full_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && full_o && !pop_i) |=> (count_o == $past(count_o)));

endmodule

// File: rtl/rx_timeout.sv
module rx_timeout #(
   parameter int DIV_W = 16,
   parameter int UNITS = 15,
   localparam int UW   = (UNITS > 1) ? $clog2(UNITS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic             cancel_i,
   input  logic [DIV_W-1:0] unit_cycles_i,
   output logic             expire_o
);

   if (UNITS < 1 || DIV_W < 1) begin : g_bad_cfg
      $error("rx_timeout: UNITS and DIV_W must be at least 1");
   end

   logic             armed_q;
   logic [DIV_W-1:0] pcnt_q;
   logic [DIV_W-1:0] lim;
   logic             tick;
   logic             last_unit;

   assign lim      = (unit_cycles_i == '0) ? DIV_W'(1) : unit_cycles_i;
   assign tick     = armed_q && (pcnt_q == lim - DIV_W'(1));
   assign expire_o = tick && last_unit;

   if (UNITS > 1) begin : g_units
      logic [UW-1:0] ucnt_q;
      assign last_unit = (ucnt_q == UW'(UNITS - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             ucnt_q <= '0;
         else if (restart_i || cancel_i)         ucnt_q <= '0;
         else if (expire_o)                      ucnt_q <= '0;
         else if (tick)                          ucnt_q <= ucnt_q + UW'(1);
      end
   end else begin : g_single
      assign last_unit = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         pcnt_q  <= '0;
      end else if (restart_i) begin
         armed_q <= 1'b1;
         pcnt_q  <= '0;
      end else if (cancel_i || expire_o) begin
         armed_q <= 1'b0;
         pcnt_q  <= '0;
      end else if (armed_q) begin
         pcnt_q  <= tick ? '0 : pcnt_q + DIV_W'(1);
      end
   end

   assert_expire_disarms_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_o && !restart_i) |=> !armed_q);

   assert_expire_needs_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
      expire_o |-> armed_q);

endmodule

// File: rtl/serial_fifo_port.sv
module serial_fifo_port
   import serial_port_pkg::*;
#(
   parameter int ADDR_W   = 5,
   parameter int DEPTH    = 16,
   parameter int DIV_W    = 16,
   parameter int TO_UNITS = 15,
   localparam int CW      = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   input  logic              brk_evt,
   input  logic [DIV_W-1:0]  unit_cycles,
   output logic              tx_push,
   output logic [7:0]        tx_data,
   output logic              rx_irq,
   output logic              tx_irq
);

   if (ADDR_W != 5) begin : g_bad_addr
      $error("serial_fifo_port: register map needs ADDR_W of 5");
   end
   if (DEPTH < 16 || DEPTH > 128 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("serial_fifo_port: DEPTH must be a power of two in 16..128");
   end

   logic [7:0]   mode_q, ctrl_q, fctl_q;
   stat_flags_t  flags_q, flags_d;
   logic         rx_irq_d;

   logic         sel_mode, sel_ctrl, sel_txd, sel_stat, sel_rxd, sel_fctl, sel_lvl;
   logic         wr_mode, wr_ctrl, wr_txd, wr_stat, wr_fctl, rd_stat;
   logic [7:0]   q_dout;
   logic [CW-1:0] q_count;
   logic         q_full, q_empty;
   logic         q_push, accept, pop;
   logic [CW:0]  lvl_next, trig_ext;
   logic         hit_trig, restart, expire;

   // Address decode
   assign sel_mode = (bus_addr == OFS_MODE);
   assign sel_ctrl = (bus_addr == OFS_CTRL);
   assign sel_txd  = (bus_addr == OFS_TXD);
   assign sel_stat = (bus_addr == OFS_STAT);
   assign sel_rxd  = (bus_addr == OFS_RXD);
   assign sel_fctl = (bus_addr == OFS_FCTL);
   assign sel_lvl  = (bus_addr == OFS_LVL);

   assign wr_mode = bus_wr && sel_mode;
   assign wr_ctrl = bus_wr && sel_ctrl;
   assign wr_txd  = bus_wr && sel_txd;
   assign wr_stat = bus_wr && sel_stat;
   assign wr_fctl = bus_wr && sel_fctl;
   assign rd_stat = bus_rd && sel_stat;

   // Receive queue
   assign q_push = rx_valid && ctrl_q[CT_RXEN];
   assign accept = q_push && !q_full;
   assign pop    = bus_rd && sel_rxd && !q_empty;

   rxq_store #(.DEPTH(DEPTH), .DW(8)) i_queue (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (q_push),
      .pop_i   (pop),
      .din_i   (rx_byte),
      .dout_o  (q_dout),
      .count_o (q_count),
      .full_o  (q_full),
      .empty_o (q_empty)
   );

   assign trig_ext = {{(CW + 1 - 5){1'b0}}, trig_level(fctl_q[7:6])};
   assign lvl_next = {1'b0, q_count} + {{CW{1'b0}}, accept} - {{CW{1'b0}}, pop};
   assign hit_trig = accept && (lvl_next >= trig_ext);
   assign restart  = accept && !hit_trig;

   rx_timeout #(.DIV_W(DIV_W), .UNITS(TO_UNITS)) i_timeout (
      .clk           (clk),
      .rst_n         (rst_n),
      .restart_i     (restart),
      .cancel_i      (hit_trig),
      .unit_cycles_i (unit_cycles),
      .expire_o      (expire)
   );

   // Flag and interrupt next state: clears first, then set events
   always_comb begin
      flags_d  = flags_q;
      rx_irq_d = rx_irq;
      if (wr_stat) begin
         flags_d.tend = flags_q.tend & bus_wdata[ST_TEND];
         flags_d.tde  = flags_q.tde  & bus_wdata[ST_TDE];
         flags_d.brk  = flags_q.brk  & bus_wdata[ST_BRK];
         flags_d.rdf  = flags_q.rdf  & bus_wdata[ST_RDF];
         flags_d.dr   = flags_q.dr   & bus_wdata[ST_DR];
         if (!bus_wdata[ST_RDF] || !bus_wdata[ST_DR]) rx_irq_d = 1'b0;
      end
      if (wr_ctrl && !bus_wdata[CT_TXEN]) flags_d.tend = 1'b1;
      if (rd_stat && ctrl_q[CT_TXEN]) begin
         flags_d.tde  = 1'b1;
         flags_d.tend = 1'b1;
      end
      if (brk_evt) flags_d.brk = 1'b1;
      if (pop && (lvl_next < trig_ext)) flags_d.rdf = 1'b0;
      if (hit_trig) begin
         flags_d.rdf = 1'b1;
         if (ctrl_q[CT_RXIE]) rx_irq_d = 1'b1;
      end
      if (expire) begin
         flags_d.rdf = 1'b1;
         flags_d.dr  = 1'b1;
         if (ctrl_q[CT_RXIE]) rx_irq_d = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         ctrl_q  <= CTRL_RST;
         fctl_q  <= '0;
         flags_q <= '{tend: 1'b1, tde: 1'b1, brk: 1'b0, rdf: 1'b0, dr: 1'b0};
         rx_irq  <= 1'b0;
         tx_irq  <= 1'b0;
         tx_push <= 1'b0;
         tx_data <= '0;
      end else begin
         flags_q <= flags_d;
         rx_irq  <= rx_irq_d;
         tx_push <= wr_txd;
         if (wr_txd)  tx_data <= bus_wdata;
         if (wr_mode) mode_q  <= bus_wdata & MODE_MASK;
         if (wr_fctl) fctl_q  <= bus_wdata;
         if (wr_ctrl) begin
            ctrl_q <= bus_wdata & CTRL_MASK;
            tx_irq <= bus_wdata[CT_TXIE];
         end
      end
   end

   // Read data
   always_comb begin
      bus_rdata = '0;
      if (sel_mode) bus_rdata = mode_q;
      if (sel_ctrl) bus_rdata = ctrl_q;
      if (sel_stat) bus_rdata = {1'b0, flags_q.tend, flags_q.tde, flags_q.brk,
                                 2'b00, flags_q.rdf, flags_q.dr};
      if (sel_rxd)  bus_rdata = q_empty ? 8'h00 : q_dout;
      if (sel_fctl) bus_rdata = fctl_q;
      if (sel_lvl)  bus_rdata = {{(8 - CW){1'b0}}, q_count};
   end

   assert_stat_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stat |-> (bus_rdata[7] == 1'b0 && bus_rdata[3:2] == 2'b00));

   assert_clear_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && (!bus_wdata[ST_RDF] || !bus_wdata[ST_DR]) && !accept && !expire)
      |=> !rx_irq);

   assert_trig_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_trig && ctrl_q[CT_RXIE] && !bus_wr) |=> (rx_irq && flags_q.rdf));

   assert_txirq_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> (tx_irq == $past(bus_wdata[CT_TXIE])));

   assert_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && ctrl_q[CT_TXEN] && !bus_wr) |=> (flags_q.tde && flags_q.tend));

   assert_tx_pulse_R14: assert property (@(posedge clk) disable iff (!rst_n)
      tx_push |=> !tx_push || $past(wr_txd));

endmodule

// File: tb/test_serial_fifo_port.sv
module test_serial_fifo_port;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        brk_evt = 1'b0;
   logic [15:0] unit_cycles = 16'd4;
   logic        tx_push;
   logic [7:0]  tx_data;
   logic        rx_irq;
   logic        tx_irq;

   int vectors = 0;
   int miscompares = 0;

   logic [7:0] exp_q  [$];
   string      req_q  [$];
   logic [4:0] addr_q [$];

   always #2 clk = ~clk;

   serial_fifo_port i_serial_fifo_port (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_addr    (bus_addr),
      .bus_wr      (bus_wr),
      .bus_rd      (bus_rd),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .rx_valid    (rx_valid),
      .rx_byte     (rx_byte),
      .brk_evt     (brk_evt),
      .unit_cycles (unit_cycles),
      .tx_push     (tx_push),
      .tx_data     (tx_data),
      .rx_irq      (rx_irq),
      .tx_irq      (tx_irq)
   );

   // Monitor: compares read data inside each read cycle
   always @(negedge clk) begin
      if (bus_rd && exp_q.size() > 0) begin
         logic [7:0] e;
         string      r;
         logic [4:0] a;
         e = exp_q.pop_front();
         r = req_q.pop_front();
         a = addr_q.pop_front();
         vectors++;
         if (bus_rdata !== e) begin
            miscompares++;
            $display("FAIL %s read 0x%02h actual=0x%02h expected=0x%02h", r, a, bus_rdata, e);
         end
      end
   end

   task automatic rd_exp(input logic [4:0] a, input logic [7:0] e, input string r);
      exp_q.push_back(e);
      req_q.push_back(r);
      addr_q.push_back(a);
      @(posedge clk); #1;
      bus_addr = a;
      bus_rd   = 1'b1;
      @(posedge clk); #1;
      bus_rd   = 1'b0;
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(posedge clk); #1;
      bus_wr    = 1'b0;
   endtask

   task automatic push(input logic [7:0] b);
      @(posedge clk); #1;
      rx_valid = 1'b1;
      rx_byte  = b;
      @(posedge clk); #1;
      rx_valid = 1'b0;
   endtask

   task automatic chk(input logic [7:0] act_unused, input logic [7:0] e, input string r, input int which);
      logic [7:0] act;
      @(negedge clk);
      case (which)
         0: act = {7'd0, rx_irq};
         1: act = {7'd0, tx_irq};
         2: act = {7'd0, tx_push};
         default: act = tx_data;
      endcase
      if (act_unused != 8'h00) act = act;
      vectors++;
      if (act !== e) begin
         miscompares++;
         $display("FAIL %s pin%0d actual=0x%02h expected=0x%02h", r, which, act, e);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin
      #(4 * 200000);
      miscompares++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      summary();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R11 reset state
      chk(0, 8'h00, "R11 rx_irq", 0);
      chk(0, 8'h00, "R11 tx_irq", 1);
      chk(0, 8'h00, "R11 tx_push", 2);
      rd_exp(5'h10, 8'h60, "R11 R2 status");
      rd_exp(5'h08, 8'h20, "R11 control");
      rd_exp(5'h18, 8'h00, "R11 queue control");
      rd_exp(5'h1C, 8'h00, "R11 level");
      rd_exp(5'h14, 8'h00, "R1 empty read");
      rd_exp(5'h00, 8'h00, "R11 mode");

      // R8 masks and transmit interrupt
      wr(5'h00, 8'hFF);
      rd_exp(5'h00, 8'h7B, "R8 mode mask");
      wr(5'h08, 8'hDF);
      chk(0, 8'h01, "R8 tx_irq high", 1);
      rd_exp(5'h08, 8'hDA, "R8 control mask");
      wr(5'h08, 8'h10);
      chk(0, 8'h00, "R8 tx_irq low", 1);

      // R3 clear-by-zero, R9 re-arm
      wr(5'h10, 8'h00);
      rd_exp(5'h10, 8'h00, "R3 all cleared");
      wr(5'h08, 8'h30);
      rd_exp(5'h10, 8'h00, "R9 value before re-arm");
      rd_exp(5'h10, 8'h60, "R9 re-armed");
      wr(5'h10, 8'hDF);
      rd_exp(5'h10, 8'h40, "R3 ones keep flags");
      wr(5'h08, 8'h10);
      wr(5'h10, 8'h00);
      wr(5'h08, 8'h10);
      rd_exp(5'h10, 8'h40, "R8 control bit5 clear sets tend");

      // R10 break
      @(posedge clk); #1 brk_evt = 1'b1;
      @(posedge clk); #1 brk_evt = 1'b0;
      rd_exp(5'h10, 8'h50, "R10 break flag");
      wr(5'h10, 8'hEF);
      rd_exp(5'h10, 8'h40, "R3 break cleared");

      // R10 receive disabled
      wr(5'h08, 8'h00);
      push(8'h11);
      rd_exp(5'h1C, 8'h00, "R10 byte ignored");
      wr(5'h08, 8'h10);

      // R5 / R7 trigger 1
      push(8'hA1);
      chk(0, 8'h00, "R5 no irq when disabled", 0);
      rd_exp(5'h10, 8'h42, "R5 threshold flag");
      rd_exp(5'h1C, 8'h01, "R1 level one");
      rd_exp(5'h14, 8'hA1, "R1 pop byte");
      rd_exp(5'h10, 8'h40, "R7 threshold cleared");

      // R13 trigger 4 and R6 timeout without irq
      wr(5'h18, 8'h40);
      rd_exp(5'h18, 8'h40, "R13 queue control");
      push(8'h31); push(8'h32); push(8'h33);
      rd_exp(5'h10, 8'h40, "R13 below trigger 4");
      repeat (40) @(posedge clk);
      rd_exp(5'h10, 8'h40, "R6 not yet expired");
      repeat (20) @(posedge clk);
      rd_exp(5'h10, 8'h43, "R6 timeout flags");
      wr(5'h10, 8'hFC);
      rd_exp(5'h10, 8'h40, "R3 rx flags cleared");
      rd_exp(5'h14, 8'h31, "R1 order 0");
      rd_exp(5'h14, 8'h32, "R1 order 1");
      rd_exp(5'h14, 8'h33, "R1 order 2");

      // R5 / R4 / R7 with interrupt enabled
      wr(5'h08, 8'h50);
      push(8'h41); push(8'h42); push(8'h43);
      chk(0, 8'h00, "R5 irq low below trigger", 0);
      push(8'h44);
      chk(0, 8'h01, "R5 irq at trigger", 0);
      rd_exp(5'h10, 8'h42, "R5 threshold at 4");
      rd_exp(5'h14, 8'h41, "R1 pop 41");
      rd_exp(5'h10, 8'h40, "R7 below trigger clears");
      chk(0, 8'h01, "R4 irq held until status write", 0);
      wr(5'h10, 8'hFD);
      chk(0, 8'h00, "R4 irq dropped", 0);
      rd_exp(5'h14, 8'h42, "R1 pop 42");
      rd_exp(5'h14, 8'h43, "R1 pop 43");
      rd_exp(5'h14, 8'h44, "R1 pop 44");
      rd_exp(5'h1C, 8'h00, "R1 level empty");

      // R6 timeout with irq
      push(8'h55);
      chk(0, 8'h00, "R6 irq low before timeout", 0);
      repeat (70) @(posedge clk);
      chk(0, 8'h01, "R6 irq on timeout", 0);
      rd_exp(5'h10, 8'h43, "R6 timeout flags irq");
      wr(5'h10, 8'hFE);
      chk(0, 8'h00, "R4 irq dropped by dr clear", 0);
      rd_exp(5'h10, 8'h42, "R3 only dr cleared");
      rd_exp(5'h14, 8'h55, "R1 pop 55");
      rd_exp(5'h10, 8'h40, "R7 cleared after pop");

      // R12 overflow
      wr(5'h08, 8'h10);
      wr(5'h18, 8'h00);
      for (int i = 0; i < 18; i++) push(8'h80 + 8'(i));
      rd_exp(5'h1C, 8'h10, "R12 level saturates");
      for (int i = 0; i < 16; i++) rd_exp(5'h14, 8'h80 + 8'(i), "R12 kept bytes");
      rd_exp(5'h14, 8'h00, "R12 extra bytes dropped");
      rd_exp(5'h10, 8'h40, "R7 drained");

      // R13 trigger 14
      wr(5'h18, 8'hC0);
      for (int i = 0; i < 13; i++) push(8'h60 + 8'(i));
      rd_exp(5'h10, 8'h40, "R13 below trigger 14");
      push(8'h6D);
      rd_exp(5'h10, 8'h42, "R13 trigger 14 reached");
      for (int i = 0; i < 14; i++) rd_exp(5'h14, 8'h60 + 8'(i), "R1 drain 14");
      rd_exp(5'h10, 8'h40, "R7 trigger 14 cleared");

      // R13 trigger 8
      wr(5'h18, 8'h80);
      for (int i = 0; i < 7; i++) push(8'h20 + 8'(i));
      rd_exp(5'h10, 8'h40, "R13 below trigger 8");
      push(8'h27);
      rd_exp(5'h10, 8'h42, "R13 trigger 8 reached");
      for (int i = 0; i < 8; i++) rd_exp(5'h14, 8'h20 + 8'(i), "R1 drain 8");

      // R14 transmit strobe
      wr(5'h0C, 8'h5A);
      chk(0, 8'h01, "R14 tx_push pulse", 2);
      chk(0, 8'h00, "R14 tx_push single cycle", 2);
      chk(0, 8'h5A, "R14 tx_data", 3);

      repeat (4) @(posedge clk);
      summary();
   end

endmodule